// File: doc/BRIEF.md
# Watchdog Control Register with Always-On Lock

This block sits in front of a watchdog counter and owns its control register. Software writes the register over a simple register-bus port. The write strobes for two neighbouring setup registers, one for configuration and one for early warning, pass through the block, which gates them. The block applies the protection rules to every write. At reset, every control bit is loaded from a nonvolatile user configuration word.

A lock bit can only be set, never cleared by software. Once it is set, the watchdog is forced on and all setup registers are frozen. Only a power-on reset clears the lock. A system reset keeps it. While the lock is clear, the enable bit decides whether the watchdog runs. The two mode bits (window mode and run-in-standby) can be changed only while the watchdog is disabled.

Each accepted control write sends the enable bit across to the watchdog clock domain with a toggle handshake. A busy flag is high for the whole handoff, and any enable change written during that time is ignored. The run and window outputs are delivered in the watchdog clock domain through synchronizer flops.

Top module: `wdg_lock_ctrl`

## Requirements
- R1: The control register reads back the lock bit at bit 7, the run-in-standby bit at bit 6, the window-mode bit at bit 2 and the enable bit at bit 1. Bits 5:3 and bit 0 always read 0, whatever is written to them.
- R2: While power-on reset is low, bits 7, 6, 2 and 1 of the register take the values of the same bits of the configuration word.
- R3: Once the lock bit (bit 7) is 1, writing 0 to it has no effect. A system reset keeps it at 1. Only a power-on reset returns it to configuration bit 7.
- R4: While the lock bit is 1, control writes change no bit, and the configuration and early-warning write strobes are held low at their gated outputs. While the lock bit is 0, those strobes pass through unchanged.
- R5: A control write changes the enable bit (bit 1) only when the lock bit is 0 and the busy flag is 0.
- R6: A control write changes the run-in-standby and window-mode bits only when the lock bit is 0 and the enable bit is 0.
- R7: Each control write accepted while the lock bit is 0 and busy is 0 raises the busy flag in the next cycle. Busy stays high until the new enable value has reached the watchdog domain and the acknowledge has come back. While busy is high, the enable bit keeps its value.
- R8: In the watchdog clock domain, the run output equals (enable OR lock) AND NOT (standby AND NOT run-in-standby), after synchronization.
- R9: In the watchdog clock domain, the window output follows the window-mode bit after synchronization.
- R10: While system reset is low and power-on reset is high, the run-in-standby, window-mode and enable bits reload from configuration bits 6, 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sys_rst_n | input | 1 | System reset, active low, asynchronous assert |
| wclk | input | 1 | Watchdog counter clock |
| ucfg | input | 8 | Nonvolatile configuration word, same bit layout as the register |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sync_busy | output | 1 | Enable handoff in progress |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wr_ok | output | 1 | Gated configuration write strobe |
| ew_wr | input | 1 | Early-warning register write strobe |
| ew_wr_ok | output | 1 | Gated early-warning write strobe |
| standby | input | 1 | Standby sleep indication, level |
| wd_run | output | 1 | Counter run enable, watchdog domain |
| wd_window | output | 1 | Window mode select, watchdog domain |

## Verification
A wrong stored bit in the bus domain shows up on the read data in the first bus cycle after the write or reset that caused it. A stray busy flag shows up as a dropped enable change on the next write. A stuck handshake keeps busy high indefinitely, so the wait for the handoff to complete times out. Errors in the watchdog-domain path appear on the run and window outputs within a few watchdog clock cycles after busy falls. The bench reads those outputs only after that settling time.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int REG_W   = 8;
  localparam int AO_BIT  = 7;
  localparam int RS_BIT  = 6;
  localparam int WEN_BIT = 2;
  localparam int EN_BIT  = 1;

  function automatic logic [REG_W-1:0] pack_ctrl(input logic ao, input logic rs,
                                                 input logic wen, input logic en);
    logic [REG_W-1:0] v;
    v          = '0;
    v[AO_BIT]  = ao;
    v[RS_BIT]  = rs;
    v[WEN_BIT] = wen;
    v[EN_BIT]  = en;
    return v;
  endfunction
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q[0] <= '0;
    else        st_q[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[i] <= '0;
        else        st_q[i] <= st_q[i-1];
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/wdg_ctrl_regs.sv
module wdg_ctrl_regs
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             sys_rst_n,
  input  logic [REG_W-1:0] ucfg,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             busy,
  output logic             ao,
  output logic             rs,
  output logic             wen,
  output logic             en,
  output logic             launch
);
  logic ao_q, rs_q, wen_q, en_q;
  logic ao_d, rs_d, wen_d, en_d;
  logic ao_ld, mode_ld, en_ld;
  logic unused_bits;

  assign unused_bits = ^{ucfg, wdata};

  always_comb begin
    ao_ld   = 1'b0;
    ao_d    = ao_q;
    if (!sys_rst_n) begin
      ao_ld = 1'b1;
      ao_d  = ao_q | ucfg[AO_BIT];
    end else if (wr && !ao_q && wdata[AO_BIT]) begin
      ao_ld = 1'b1;
      ao_d  = 1'b1;
    end
  end

  always_comb begin
    en_ld   = wr && !ao_q && !busy;
    en_d    = wdata[EN_BIT];
    mode_ld = wr && !ao_q && !en_q;
    rs_d    = wdata[RS_BIT];
    wen_d   = wdata[WEN_BIT];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     ao_q <= ucfg[AO_BIT];
    else if (ao_ld) ao_q <= ao_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= ucfg[EN_BIT];
    else if (en_ld) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q  <= ucfg[RS_BIT];
      wen_q <= ucfg[WEN_BIT];
    end else if (mode_ld) begin
      rs_q  <= rs_d;
      wen_q <= wen_d;
    end
  end

  assign ao     = ao_q;
  assign rs     = rs_q;
  assign wen    = wen_q;
  assign en     = en_q;
  assign launch = en_ld;
endmodule

// File: rtl/wdg_en_handoff.sv
module wdg_en_handoff #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wclk,
  input  logic wrst_n,
  input  logic launch,
  input  logic en_src,
  input  logic en_init,
  output logic busy,
  output logic en_w
);
  logic req_q, req_d;
  logic ack_s;
  logic req_s;
  logic ack_w_q;
  logic en_w_q, en_w_d, en_w_ld;

  always_comb req_d = req_q ^ launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  wdg_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk(wclk), .rst_n(wrst_n), .d(req_q), .q(req_s)
  );

  always_comb begin
    en_w_ld = req_s ^ ack_w_q;
    en_w_d  = en_src;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) ack_w_q <= 1'b0;
    else         ack_w_q <= req_s;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n)      en_w_q <= en_init;
    else if (en_w_ld) en_w_q <= en_w_d;
  end

  wdg_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_w_q), .q(ack_s)
  );

  assign busy = req_q ^ ack_s;
  assign en_w = en_w_q;
endmodule

// File: rtl/wdg_lock_ctrl.sv
module wdg_lock_ctrl
  import wdg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             wclk,
  input  logic [REG_W-1:0] ucfg,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             sync_busy,
  input  logic             cfg_wr,
  output logic             cfg_wr_ok,
  input  logic             ew_wr,
  output logic             ew_wr_ok,
  input  logic             standby,
  output logic             wd_run,
  output logic             wd_window
);
  localparam int BANK_W = 4;

  logic rst_n, wrst_n;
  logic ao, rs, wen, en, launch, busy, en_w;
  logic [BANK_W-1:0] bank_d, bank_q;
  logic s_ao, s_rs, s_wen, s_stb;

  assign rst_n = por_n & sys_rst_n;

  wdg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wrst (
    .clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_n)
  );

  wdg_ctrl_regs u_regs (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sys_rst_n(sys_rst_n),
    .ucfg(ucfg), .wr(reg_wr), .wdata(reg_wdata), .busy(busy),
    .ao(ao), .rs(rs), .wen(wen), .en(en), .launch(launch)
  );

  wdg_en_handoff #(.STAGES(SYNC_STAGES)) u_handoff (
    .clk(clk), .rst_n(rst_n), .wclk(wclk), .wrst_n(wrst_n),
    .launch(launch), .en_src(en), .en_init(ucfg[EN_BIT]),
    .busy(busy), .en_w(en_w)
  );

  assign bank_d = {ao, rs, wen, standby};

  wdg_sync #(.W(BANK_W), .STAGES(SYNC_STAGES)) u_bank (
    .clk(wclk), .rst_n(wrst_n), .d(bank_d), .q(bank_q)
  );

  assign {s_ao, s_rs, s_wen, s_stb} = bank_q;

  assign wd_run    = (en_w | s_ao) & ~(s_stb & ~s_rs);
  assign wd_window = s_wen;
  assign reg_rdata = pack_ctrl(ao, rs, wen, en);
  assign sync_busy = busy;
  assign cfg_wr_ok = cfg_wr & ~ao;
  assign ew_wr_ok  = ew_wr & ~ao;
endmodule

// File: rtl/wdg_lock_ctrl_chk.sv
module wdg_lock_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       sys_rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic       sync_busy,
  input logic       cfg_wr_ok,
  input logic       ew_wr_ok
);
  p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata[5:3] == 3'b000) && !reg_rdata[0]);

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[7] |=> reg_rdata[7]);

  p_lock_frozen_r4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    reg_rdata[7] |=> $stable(reg_rdata));

  p_lock_gates_r4: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[7] |-> (!cfg_wr_ok && !ew_wr_ok));

  p_mode_protect_r6: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (!reg_rdata[7] && reg_rdata[1]) |=> $stable(reg_rdata[6]) && $stable(reg_rdata[2]));

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (reg_wr && !reg_rdata[7] && !sync_busy) |=> sync_busy);

  p_busy_holds_en_r7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    sync_busy |=> $stable(reg_rdata[1]));
endmodule

bind wdg_lock_ctrl wdg_lock_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .sync_busy(sync_busy),
  .cfg_wr_ok(cfg_wr_ok), .ew_wr_ok(ew_wr_ok)
);

// File: tb/wdg_lock_ctrl_test.sv
module wdg_lock_ctrl_test;
  localparam int CLK_PERIOD  = 10;
  localparam int WCLK_PERIOD = 14;

  logic clk = 1'b0, wclk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b1;
  logic [7:0] ucfg = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic reg_wr = 1'b0, cfg_wr = 1'b0, ew_wr = 1'b0, standby = 1'b0;
  logic sync_busy, cfg_wr_ok, ew_wr_ok, wd_run, wd_window;

  int n_chk = 0, n_fail = 0;
  logic m_ao = 1'b0, m_rs = 1'b0, m_wen = 1'b0, m_en = 1'b0;
  logic armed = 1'b0, busy_obs = 1'b0, exp_busy = 1'b0;

  always #(CLK_PERIOD/2)  clk  = ~clk;
  always #(WCLK_PERIOD/2) wclk = ~wclk;

  wdg_lock_ctrl uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wclk(wclk), .ucfg(ucfg),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sync_busy(sync_busy), .cfg_wr(cfg_wr), .cfg_wr_ok(cfg_wr_ok),
    .ew_wr(ew_wr), .ew_wr_ok(ew_wr_ok), .standby(standby),
    .wd_run(wd_run), .wd_window(wd_window)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: one update per bus clock edge
  always @(posedge clk) begin
    exp_busy <= por_n && sys_rst_n && reg_wr && !m_ao && !busy_obs;
    if (!por_n) begin
      m_ao <= ucfg[7]; m_rs <= ucfg[6]; m_wen <= ucfg[2]; m_en <= ucfg[1];
      armed <= 1'b1;
    end else if (!sys_rst_n) begin
      m_ao <= m_ao | ucfg[7]; m_rs <= ucfg[6]; m_wen <= ucfg[2]; m_en <= ucfg[1];
    end else if (reg_wr && !m_ao) begin
      if (reg_wdata[7]) m_ao <= 1'b1;
      if (!busy_obs) m_en <= reg_wdata[1];
      if (!m_en) begin m_rs <= reg_wdata[6]; m_wen <= reg_wdata[2]; end
    end
  end

  always @(negedge clk) begin
    busy_obs = sync_busy;
    if (armed) begin
      check("R3 lock bit", {7'd0, reg_rdata[7]}, {7'd0, m_ao});
      check("R5 enable bit", {7'd0, reg_rdata[1]}, {7'd0, m_en});
      check("R6 mode bits", {6'd0, reg_rdata[6], reg_rdata[2]}, {6'd0, m_rs, m_wen});
      check("R1 unused bits", {4'd0, reg_rdata[5:3], reg_rdata[0]}, 8'h00);
      check("R4 strobe gating", {6'd0, cfg_wr_ok, ew_wr_ok},
            {6'd0, cfg_wr & ~m_ao, ew_wr & ~m_ao});
      if (exp_busy) check("R7 busy after write", {7'd0, sync_busy}, 8'h01);
    end
  end

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk); #1; reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); #1; reg_wr = 1'b0;
  endtask

  task automatic settle();
    int guard = 0;
    repeat (2) @(negedge clk);
    while (sync_busy && guard < 200) begin @(negedge clk); guard++; end
    check("R7 handoff completes", {7'd0, sync_busy}, 8'h00);
    repeat (12) @(negedge clk);
  endtask

  task automatic check_outputs();
    logic er;
    er = (m_en | m_ao) & ~(standby & ~m_rs);
    check("R8 run output", {7'd0, wd_run}, {7'd0, er});
    check("R9 window output", {7'd0, wd_window}, {7'd0, m_wen});
  endtask

  task automatic do_por(input logic [7:0] cfg);
    @(negedge clk); #1; por_n = 1'b0; ucfg = cfg;
    repeat (3) @(negedge clk); #1; por_n = 1'b1;
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired, run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_por(8'h00);
    check("R2 reset load 00", reg_rdata, 8'h00);
    check_outputs();

    write_ctrl(8'h44);          // R6: modes accepted while disabled
    settle();
    check("R6 modes written", reg_rdata, 8'h44);
    check_outputs();

    write_ctrl(8'h46);          // R5: enable on
    settle();
    check("R5 enabled", reg_rdata, 8'h46);
    check_outputs();

    write_ctrl(8'h02);          // R6: protected while enabled
    settle();
    check("R6 protected", reg_rdata, 8'h46);

    // R7: second write during busy leaves enable unchanged
    @(negedge clk); #1; reg_wr = 1'b1; reg_wdata = 8'h00;
    @(negedge clk); #1; reg_wdata = 8'h42;
    @(negedge clk); #1; reg_wr = 1'b0;
    settle();
    check("R7 enable ignored while busy", reg_rdata, 8'h40);
    check_outputs();

    standby = 1'b1;             // R8: standby with run-in-standby set, disabled
    write_ctrl(8'h02);          // clears run-in-standby, enables
    settle();
    check("R8 standby stopped", {7'd0, wd_run}, 8'h00);
    check_outputs();
    standby = 1'b0;
    settle();
    check("R8 awake running", {7'd0, wd_run}, 8'h01);

    @(negedge clk); #1; cfg_wr = 1'b1; ew_wr = 1'b1;
    @(negedge clk);
    check("R4 strobes pass unlocked", {6'd0, cfg_wr_ok, ew_wr_ok}, 8'h03);
    #1; cfg_wr = 1'b0; ew_wr = 1'b0;

    write_ctrl(8'h00);          // disable
    settle();
    write_ctrl(8'hBD);          // lock with unused bits set
    settle();
    check("R1 lock readback", reg_rdata, 8'h84);
    standby = 1'b1;
    settle();
    check_outputs();
    standby = 1'b0;

    write_ctrl(8'h46);          // R3/R4: ignored while locked
    settle();
    check("R4 locked write ignored", reg_rdata, 8'h84);
    @(negedge clk); #1; cfg_wr = 1'b1; ew_wr = 1'b1;
    @(negedge clk);
    check("R4 strobes blocked", {6'd0, cfg_wr_ok, ew_wr_ok}, 8'h00);
    #1; cfg_wr = 1'b0; ew_wr = 1'b0;
    check_outputs();

    // R10: system reset keeps lock, reloads the rest
    @(negedge clk); #1; ucfg = 8'h42; sys_rst_n = 1'b0;
    repeat (3) @(negedge clk); #1; sys_rst_n = 1'b1;
    settle();
    check("R10 sys reset reload", reg_rdata, 8'hC2);
    check_outputs();

    do_por(8'h00);
    check("R3 por clears lock", reg_rdata, 8'h00);
    check_outputs();

    do_por(8'hC6);
    check("R2 reset load C6", reg_rdata, 8'hC6);
    check_outputs();

    do_por(8'h06);
    check("R2 reset load 06", reg_rdata, 8'h06);
    @(negedge clk); #1; ucfg = 8'h00; sys_rst_n = 1'b0;
    repeat (2) @(negedge clk); #1; sys_rst_n = 1'b1;
    settle();
    check("R10 sys reset without lock", reg_rdata, 8'h00);
    check_outputs();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule